// File: doc/BRIEF.md
# Periodic Tick Down-Counter

This block is a memory-mapped tick timer for a microcontroller. A 24-bit down-counter runs from a programmable reload value to zero and then reloads, again and again. Each time it steps from one to zero it sets a sticky count flag. If the tick interrupt is on, it also raises a level interrupt-pend output toward the interrupt controller. That output stays high until the controller pulses an acknowledge input.

Software reaches three 32-bit registers over a simple register bus: control/status, reload and current value. The counter advances on every core clock, or once per rising edge of a slow external reference input, which is synchronised into the core domain first. It holds its value while the debug-halt input is high. A debugger read can be marked through a sideband input so that it does not disturb the count flag.

Top module: `tick_timer`

## Requirements
- R1: Register offsets are 0x00 control/status, 0x04 reload and 0x08 current. Any other offset reads as zero. After reset all three registers read zero and the interrupt-pend output is low.
- R2: Control bits are bit 0 enable, bit 1 tick interrupt, bit 2 clock source (1 = core clock, 0 = external reference) and bit 16 the count flag. All other bits read zero. A control write leaves the count flag unchanged.
- R3: The reload and current registers keep bits 23:0 only. Bits 31:24 always read zero.
- R4: While enabled, the counter decrements once per count-enable cycle. After reaching zero it loads the reload value on the next count-enable cycle. A reload of N therefore gives a period of N+1 count-enable cycles.
- R5: A step from 1 to 0 sets the count flag. If the tick-interrupt bit is 1, the same step raises the interrupt-pend output. If that bit is 0, the output stays low.
- R6: A control/status read returns the count flag and clears it. A read with the debug sideband high returns the flag and leaves it set.
- R7: A write of any value to the current register sets the counter to zero and clears the count flag. This write never raises the interrupt-pend output.
- R8: With a reload value of zero, the counter stops at zero and raises neither the flag nor the interrupt again.
- R9: While the debug-halt input is high, the counter holds its value. Counting resumes from that value when the input falls.
- R10: With the external source selected, the reference input passes through a two-flop synchroniser. The counter then steps once per detected rising edge and does not step otherwise.
- R11: Enabling the counter while it holds zero loads the reload value on the first count-enable cycle and does not set the flag.
- R12: The interrupt-pend output stays high until a one-cycle acknowledge pulse clears it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_addr | input | 8 | Register byte offset |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_dbg | input | 1 | Marks the current access as a debugger access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the offset |
| halt | input | 1 | Debug halt: freezes the counter |
| ref_clk | input | 1 | External reference, at least 2.5 times slower than clk |
| irq_ack | input | 1 | One-cycle acknowledge from the interrupt controller |
| irq_pend | output | 1 | Level interrupt request |

## Verification
The assertions are checked on every cycle. They cover the following:
- The flag rises only on a 1-to-0 step.
- A load from zero never sets the flag.
- Halt and a zero reload both freeze the counter.
- A current-register write leaves the counter at zero with the flag low and no new interrupt.
- The pend level holds until acknowledged.
- The synchronised reference edge lasts one cycle.

Only the bench scenarios can show the following:
- The exact N+1 period between interrupts.
- The step count produced by a train of external reference edges.
- The difference between debugger and normal reads of the flag.
- The zero read-back of upper and unmapped bits.

// File: rtl/tick_pkg.sv
package tick_pkg;

  typedef enum logic [1:0] {
    SEL_CTRL,
    SEL_RELOAD,
    SEL_CURR,
    SEL_NONE
  } sel_e;

  localparam int BIT_ENA  = 0;
  localparam int BIT_TINT = 1;
  localparam int BIT_SRC  = 2;
  localparam int BIT_FLAG = 16;

  localparam logic [7:0] OFF_CTRL   = 8'h00;
  localparam logic [7:0] OFF_RELOAD = 8'h04;
  localparam logic [7:0] OFF_CURR   = 8'h08;

  typedef struct packed {
    logic src_core;
    logic tint;
    logic ena;
  } ctrl_t;

endpackage

// File: rtl/tick_refsync.sv
module tick_refsync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic ref_in,
  output logic rise
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain[0] <= 1'b0;
    else        chain[0] <= ref_in;
  end

  for (genvar g = 1; g < CHAIN_W; g++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain[g] <= 1'b0;
      else        chain[g] <= chain[g-1];
    end
  end

  assign rise = chain[SYNC_STAGES-1] & ~chain[SYNC_STAGES];

  // R10: a detected edge yields exactly one count-enable cycle
  assert_single_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> !rise);

endmodule

// File: rtl/tick_regs.sv
module tick_regs
  import tick_pkg::*;
#(
  parameter int CNT_W  = 24,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_dbg,
  input  logic [31:0]       bus_wdata,
  input  logic              flag,
  input  logic [CNT_W-1:0]  cur,
  output ctrl_t             ctrl,
  output logic [CNT_W-1:0]  reload,
  output logic              cur_clr,
  output logic              flag_clr,
  output logic [31:0]       rdata
);
  sel_e sel;
  logic unused_wdata_hi;

  assign unused_wdata_hi = ^bus_wdata[31:CNT_W];

  always_comb begin
    if      (bus_addr == ADDR_W'(OFF_CTRL))   sel = SEL_CTRL;
    else if (bus_addr == ADDR_W'(OFF_RELOAD)) sel = SEL_RELOAD;
    else if (bus_addr == ADDR_W'(OFF_CURR))   sel = SEL_CURR;
    else                                      sel = SEL_NONE;
  end

  assign cur_clr  = bus_wr && (sel == SEL_CURR);
  assign flag_clr = bus_rd && !bus_dbg && (sel == SEL_CTRL);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl   <= '0;
      reload <= '0;
    end else if (bus_wr) begin
      if (sel == SEL_CTRL) begin
        ctrl.ena      <= bus_wdata[BIT_ENA];
        ctrl.tint     <= bus_wdata[BIT_TINT];
        ctrl.src_core <= bus_wdata[BIT_SRC];
      end
      if (sel == SEL_RELOAD) reload <= bus_wdata[CNT_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_CTRL: begin
        rdata[BIT_ENA]  = ctrl.ena;
        rdata[BIT_TINT] = ctrl.tint;
        rdata[BIT_SRC]  = ctrl.src_core;
        rdata[BIT_FLAG] = flag;
      end
      SEL_RELOAD: rdata = 32'(reload);
      SEL_CURR:   rdata = 32'(cur);
      default:    rdata = '0;
    endcase
  end

  // R2: control fields change only through a control write
  assert_ctrl_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && sel == SEL_CTRL) |=> $stable(ctrl));

endmodule

// File: rtl/tick_counter.sv
module tick_counter #(
  parameter int CNT_W = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ena,
  input  logic             tint,
  input  logic             cnt_en,
  input  logic             halt,
  input  logic [CNT_W-1:0] reload,
  input  logic             cur_clr,
  input  logic             flag_clr,
  input  logic             ack,
  output logic [CNT_W-1:0] cur,
  output logic             flag,
  output logic             pend,
  output logic             tick_hit,
  output logic             load_evt
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  function automatic logic [CNT_W-1:0] next_count(input logic [CNT_W-1:0] c,
                                                  input logic [CNT_W-1:0] r);
    return (c == '0) ? r : c - ONE;
  endfunction

  logic step;

  assign step     = ena && cnt_en && !halt && !cur_clr;
  assign tick_hit = step && (cur == ONE);
  assign load_evt = step && (cur == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur  <= '0;
      flag <= 1'b0;
      pend <= 1'b0;
    end else begin
      if (cur_clr)   cur <= '0;
      else if (step) cur <= next_count(cur, reload);

      if (tick_hit)                 flag <= 1'b1;
      else if (cur_clr || flag_clr) flag <= 1'b0;

      if (tick_hit && tint) pend <= 1'b1;
      else if (ack)         pend <= 1'b0;
    end
  end

  // R5: the flag rises only on a step from one to zero
  assert_flag_on_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> ($past(cur) == ONE && cur == '0));

  // R5: the interrupt rises only with the tick interrupt enabled
  assert_pend_needs_tint_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(tint));

  // R11: a load from zero never sets the flag
  assert_load_no_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (load_evt && !flag) |=> !flag);

  // R9: halt freezes the counter
  assert_halt_freeze_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (halt && !cur_clr) |=> $stable(cur));

  // R8: zero reload keeps the counter parked at zero
  assert_zero_reload_park_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (cur == '0 && reload == '0) |=> (cur == '0));

  // R7: clearing the current value is quiet
  assert_clear_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
    cur_clr |=> (cur == '0 && !flag && !$rose(pend)));

  // R12: the pend level holds until acknowledged
  assert_pend_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (pend && !ack) |=> pend);

endmodule

// File: rtl/tick_timer.sv
module tick_timer
  import tick_pkg::*;
#(
  parameter int CNT_W       = 24,
  parameter int ADDR_W      = 8,
  parameter int SYNC_STAGES = 2,
  parameter bit HAS_EXT_REF = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic              bus_dbg,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              halt,
  input  logic              ref_clk,
  input  logic              irq_ack,
  output logic              irq_pend
);
  ctrl_t            ctrl;
  logic [CNT_W-1:0] reload;
  logic [CNT_W-1:0] cur;
  logic             flag;
  logic             cur_clr;
  logic             flag_clr;
  logic             ref_rise;
  logic             cnt_en;
  logic             tick_hit;
  logic             load_evt;

  if (HAS_EXT_REF) begin : g_ext
    tick_refsync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_in (ref_clk),
      .rise   (ref_rise)
    );
  end else begin : g_noext
    logic unused_ref;
    assign unused_ref = ref_clk;
    assign ref_rise   = 1'b0;
  end

  assign cnt_en = ctrl.src_core ? 1'b1 : ref_rise;

  tick_regs #(.CNT_W(CNT_W), .ADDR_W(ADDR_W)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_addr  (bus_addr),
    .bus_wr    (bus_wr),
    .bus_rd    (bus_rd),
    .bus_dbg   (bus_dbg),
    .bus_wdata (bus_wdata),
    .flag      (flag),
    .cur       (cur),
    .ctrl      (ctrl),
    .reload    (reload),
    .cur_clr   (cur_clr),
    .flag_clr  (flag_clr),
    .rdata     (bus_rdata)
  );

  tick_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_n),
    .ena      (ctrl.ena),
    .tint     (ctrl.tint),
    .cnt_en   (cnt_en),
    .halt     (halt),
    .reload   (reload),
    .cur_clr  (cur_clr),
    .flag_clr (flag_clr),
    .ack      (irq_ack),
    .cur      (cur),
    .flag     (flag),
    .pend     (irq_pend),
    .tick_hit (tick_hit),
    .load_evt (load_evt)
  );

  // R10: with the external source, steps happen only on reference edges
  assert_ext_gate_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (!ctrl.src_core && !ref_rise && !cur_clr) |=> $stable(cur));

endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  bus_addr = '0;
  logic        bus_wr = 1'b0;
  logic        bus_rd = 1'b0;
  logic        bus_dbg = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        halt = 1'b0;
  logic        ref_clk = 1'b0;
  logic        irq_ack = 1'b0;
  logic        irq_pend;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 1'b0;

  localparam logic [7:0] A_CTRL = 8'h00;
  localparam logic [7:0] A_RLD  = 8'h04;
  localparam logic [7:0] A_CUR  = 8'h08;

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  tick_timer uut (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_rd(bus_rd), .bus_dbg(bus_dbg), .bus_wdata(bus_wdata),
    .bus_rdata(bus_rdata), .halt(halt), .ref_clk(ref_clk),
    .irq_ack(irq_ack), .irq_pend(irq_pend)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, input bit dbg, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1; bus_dbg = dbg;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0; bus_dbg = 1'b0;
  endtask

  task automatic ack_pulse();
    @(negedge clk); irq_ack = 1'b1;
    @(negedge clk); irq_ack = 1'b0;
  endtask

  task automatic wait_cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic t_reset();
    logic [31:0] d;
    chk("R1 pend after reset", {31'b0, irq_pend}, 32'h0);
    rd(A_CTRL, 1'b0, d); chk("R1 ctrl reset", d, 32'h0);
    rd(A_RLD,  1'b0, d); chk("R1 reload reset", d, 32'h0);
    rd(A_CUR,  1'b0, d); chk("R1 current reset", d, 32'h0);
  endtask

  task automatic t_fields();
    logic [31:0] d;
    wr(A_RLD, 32'hFFFF_FFFF);
    rd(A_RLD, 1'b0, d); chk("R3 reload upper bits", d, 32'h00FF_FFFF);
    wr(A_CUR, 32'hFFFF_FFFF);
    rd(A_CUR, 1'b0, d); chk("R3 current write clears", d, 32'h0);
    wr(A_CTRL, 32'hFFFE_FFF8);
    rd(A_CTRL, 1'b0, d); chk("R2 unused ctrl bits", d, 32'h0);
    rd(8'h0C, 1'b0, d);  chk("R1 unmapped offset", d, 32'h0);
  endtask

  task automatic t_first_load();
    logic [31:0] d;
    wr(A_RLD, 32'd5);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h7);
    rd(A_CTRL, 1'b0, d); chk("R11 no flag on first load", {31'b0, d[16]}, 32'h0);
    rd(A_CUR, 1'b0, d);  chk("R11 loaded then counting", d, 32'd3);
    chk("R11 no pend on first load", {31'b0, irq_pend}, 32'h0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_period();
    int t1;
    int t2;
    wr(A_CTRL, 32'h0);
    wr(A_RLD, 32'd4);
    wr(A_CUR, 32'd0);
    ack_pulse();
    wr(A_CTRL, 32'h7);
    while (!irq_pend) @(negedge clk);
    t1 = cyc;
    wait_cyc(2);
    chk("R12 pend holds without ack", {31'b0, irq_pend}, 32'h1);
    ack_pulse();
    chk("R12 ack clears pend", {31'b0, irq_pend}, 32'h0);
    while (!irq_pend) @(negedge clk);
    t2 = cyc;
    chk("R4 period is reload+1", t2 - t1, 32'd5);
  endtask

  task automatic t_flag_read();
    logic [31:0] d;
    wr(A_CTRL, 32'h5);
    ack_pulse();
    wait_cyc(12);
    wr(A_CTRL, 32'h0);
    chk("R5 no pend with tick interrupt off", {31'b0, irq_pend}, 32'h0);
    rd(A_CTRL, 1'b1, d); chk("R6 debug read sees flag", {31'b0, d[16]}, 32'h1);
    rd(A_CTRL, 1'b0, d); chk("R6 debug read kept flag", {31'b0, d[16]}, 32'h1);
    rd(A_CTRL, 1'b0, d); chk("R6 normal read cleared flag", {31'b0, d[16]}, 32'h0);
    wr(A_CTRL, 32'h0001_0000);
    rd(A_CTRL, 1'b0, d); chk("R2 ctrl write leaves flag", d, 32'h0);
  endtask

  task automatic t_cur_clear();
    logic [31:0] d;
    wr(A_RLD, 32'd6);
    wr(A_CTRL, 32'h7);
    wait_cyc(15);
    wr(A_CTRL, 32'h0);
    ack_pulse();
    rd(A_CTRL, 1'b1, d); chk("R7 flag set before clear", {31'b0, d[16]}, 32'h1);
    wr(A_CUR, 32'h00AB_CDEF);
    rd(A_CUR, 1'b0, d);  chk("R7 current zeroed", d, 32'h0);
    rd(A_CTRL, 1'b1, d); chk("R7 flag cleared", {31'b0, d[16]}, 32'h0);
    chk("R7 no pend from clear", {31'b0, irq_pend}, 32'h0);
  endtask

  task automatic t_zero_reload();
    logic [31:0] d;
    wr(A_RLD, 32'd3);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h7);
    wait_cyc(3);
    wr(A_RLD, 32'd0);
    wait_cyc(20);
    ack_pulse();
    rd(A_CTRL, 1'b0, d);
    wait_cyc(10);
    rd(A_CUR, 1'b0, d);  chk("R8 counter parked at zero", d, 32'h0);
    rd(A_CTRL, 1'b0, d); chk("R8 flag not raised again", {31'b0, d[16]}, 32'h0);
    chk("R8 pend not raised again", {31'b0, irq_pend}, 32'h0);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_halt();
    logic [31:0] a;
    logic [31:0] b;
    logic [31:0] c;
    wr(A_RLD, 32'd1000);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h5);
    wait_cyc(4);
    @(negedge clk); halt = 1'b1;
    rd(A_CUR, 1'b0, a);
    wait_cyc(10);
    rd(A_CUR, 1'b0, b);
    chk("R9 halted counter holds", b, a);
    @(negedge clk); halt = 1'b0; bus_addr = A_CUR;
    wait_cyc(5);
    #1 c = bus_rdata;
    chk("R9 resumes after halt", c, b - 32'd5);
    wr(A_CTRL, 32'h0);
  endtask

  task automatic t_ext();
    logic [31:0] d;
    wr(A_RLD, 32'd100);
    wr(A_CUR, 32'd0);
    wr(A_CTRL, 32'h1);
    wait_cyc(10);
    rd(A_CUR, 1'b0, d); chk("R10 no step without reference edge", d, 32'h0);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ref_clk = 1'b1;
      wait_cyc(4);
      ref_clk = 1'b0;
      wait_cyc(4);
    end
    wait_cyc(6);
    rd(A_CUR, 1'b0, d); chk("R10 one step per reference edge", d, 32'd96);
    wr(A_CTRL, 32'h0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_fields();
    t_first_load();
    t_period();
    t_flag_read();
    t_cur_clear();
    t_zero_reload();
    t_halt();
    t_ext();
    finish_run();
  end

endmodule